// File: doc/BRIEF.md
# Active Rectifier Sampling and Offset Timing Controller

This block is a clocked digital controller for a full-bridge active rectifier with two low-side switches. It watches the two low-side gate-drive levels. From their edges it derives the switch controls for two sampling-based delay-compensation loops, one per rectifier half. Each half gets five enables: a turn-on sample window, a turn-off sample window, a hold strobe, a turn-on offset enable and a turn-off offset enable. The analog sample-and-hold, buffering, error amplification and offset current injection sit outside and consume these bits.

Both gate levels are first brought into the clock domain by a synchroniser. One-cycle rise and fall pulses are then formed from them. Every window is a set/clear state bit whose set and clear come from specific gate edges. The hold strobe of a half follows the other half's turn-on sample window, but only after a programmable settling count. It is gated off whenever this half's turn-off sampling is active.

Top module: `rect_phase_ctrl`

## Requirements
- R1: While rst_ni is low, and afterwards until a gate edge arrives, every output bit is 0.
- R2: For half h (bit 0 pairs with gate_a_i as own gate, bit 1 with gate_b_i), on_smp_o[h] is set by a falling edge of the other half's gate and cleared by a rising edge of its own gate.
- R3: off_smp_o[h] is set by a falling edge of the other half's gate and cleared by a falling edge of its own gate.
- R4: on_ofs_o[h] is set by a falling edge of the other half's gate and cleared by a rising edge of its own gate.
- R5: off_ofs_o[h] is set by a rising edge of its own gate and cleared by a falling edge of the other half's gate. on_ofs_o[h] and off_ofs_o[h] are never both 1.
- R6: When a state bit receives its set and clear edges in the same cycle, the clear wins and the bit is 0 afterwards.
- R7: hold_o[h] follows on_smp_o of the other half. It rises HOLD_DLY cycles after that window opens and falls in the same cycle that window closes.
- R8: hold_o[h] is 0 whenever off_smp_o[h] is 1. Any cycle with off_smp_o[h] high restarts the settling count.
- R9: Output bit 0 belongs to the half whose own gate is gate_a_i, and bit 1 to the half whose own gate is gate_b_i.
- R10: A gate change captured at rising clock edge k shows on the window and offset outputs just after edge k+2 (with SYNC_STAGES = 2), and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gate_a_i | input | 1 | Low-side gate level of half 0 (asynchronous) |
| gate_b_i | input | 1 | Low-side gate level of half 1 (asynchronous) |
| on_smp_o | output | 2 | Turn-on sample window, one bit per half |
| off_smp_o | output | 2 | Turn-off sample window, one bit per half |
| hold_o | output | 2 | Hold strobe, one bit per half |
| on_ofs_o | output | 2 | Turn-on offset enable, one bit per half |
| off_ofs_o | output | 2 | Turn-off offset enable, one bit per half |

## Verification
The bench builds the controller with HOLD_DLY = 3 and the default two-stage synchroniser. Random gate pulses, often only two to twelve cycles long, therefore close the other half's turn-on window both before and after the hold count expires. Directed steps drive a rising and a falling edge into the same cycle to reach the clear-wins case. They also probe the two-cycle pipeline latency and the exact cycle in which the hold strobe rises.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  localparam int unsigned NUM_HALVES = 2;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/rpc_sync.sv
module rpc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= (sr_q << 1) | STAGES'(d_i);
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/rpc_edge.sv
module rpc_edge
  import rpc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  lvl_i,
  output edge_t edg_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign edg_o.rise = lvl_i & ~prev_q;
  assign edg_o.fall = ~lvl_i & prev_q;
endmodule

// File: rtl/rpc_srlat.sv
module rpc_srlat (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // clear dominates a coincident set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
  end
endmodule

// File: rtl/rpc_hold.sv
module rpc_hold #(
  parameter int unsigned DLY = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic block_i,
  output logic hold_o
);
  localparam int unsigned CNT_W = (DLY < 1) ? 1 : $clog2(DLY + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DLY);

  logic [CNT_W-1:0] cnt_q;
  logic             done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!req_i || block_i) cnt_q <= '0;
    else if (!done)             cnt_q <= cnt_q + 1'b1;
  end

  assign done   = (cnt_q == LIMIT);
  // combinational gate keeps hold off in the very cycle block rises
  assign hold_o = req_i & ~block_i & done;
endmodule

// File: rtl/rect_phase_ctrl.sv
module rect_phase_ctrl
  import rpc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_DLY    = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       gate_a_i,
  input  logic       gate_b_i,
  output logic [1:0] on_smp_o,
  output logic [1:0] off_smp_o,
  output logic [1:0] hold_o,
  output logic [1:0] on_ofs_o,
  output logic [1:0] off_ofs_o
);
  localparam int unsigned NH = NUM_HALVES;

  logic [NH-1:0] gate_raw;
  logic [NH-1:0] gate_sync;
  edge_t         edg [NH];

  assign gate_raw = {gate_b_i, gate_a_i};

  for (genvar g = 0; g < NH; g++) begin : g_in
    rpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (gate_raw[g]),
      .q_o   (gate_sync[g])
    );
    rpc_edge u_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (gate_sync[g]),
      .edg_o (edg[g])
    );
  end

  for (genvar h = 0; h < NH; h++) begin : g_half
    localparam int unsigned OTH = NH - 1 - h;

    rpc_srlat u_on_smp (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (edg[OTH].fall),
      .clr_i (edg[h].rise),
      .q_o   (on_smp_o[h])
    );
    rpc_srlat u_off_smp (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (edg[OTH].fall),
      .clr_i (edg[h].fall),
      .q_o   (off_smp_o[h])
    );
    rpc_srlat u_on_ofs (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (edg[OTH].fall),
      .clr_i (edg[h].rise),
      .q_o   (on_ofs_o[h])
    );
    rpc_srlat u_off_ofs (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (edg[h].rise),
      .clr_i (edg[OTH].fall),
      .q_o   (off_ofs_o[h])
    );
    rpc_hold #(.DLY(HOLD_DLY)) u_hold (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (on_smp_o[OTH]),
      .block_i(off_smp_o[h]),
      .hold_o (hold_o[h])
    );
  end
endmodule

// File: rtl/rpc_checker.sv
module rpc_checker #(
  parameter int unsigned HOLD_DLY = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] on_smp_o,
  input logic [1:0] off_smp_o,
  input logic [1:0] hold_o,
  input logic [1:0] on_ofs_o,
  input logic [1:0] off_ofs_o
);
  for (genvar h = 0; h < 2; h++) begin : g_chk
    localparam int unsigned OTH = 1 - h;

    a_r8_hold_vs_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(hold_o[h] && off_smp_o[h]));

    a_r5_ofs_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(on_ofs_o[h] && off_ofs_o[h]));

    a_r7_hold_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold_o[h] |-> on_smp_o[OTH]);

    a_r4_ofs_tracks_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
      on_ofs_o[h] == on_smp_o[h]);

    if (HOLD_DLY > 0) begin : g_dly
      a_r7_hold_delayed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hold_o[h]) |-> $past(on_smp_o[OTH]));
    end
  end
endmodule

bind rect_phase_ctrl rpc_checker #(.HOLD_DLY(HOLD_DLY)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .on_smp_o (on_smp_o),
  .off_smp_o(off_smp_o),
  .hold_o   (hold_o),
  .on_ofs_o (on_ofs_o),
  .off_ofs_o(off_ofs_o)
);

// File: tb/rect_phase_ctrl_bench.sv
`timescale 1ns/1ps
module rect_phase_ctrl_bench;
  localparam int DLY = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ga = 1'b0;
  logic       gb = 1'b0;
  logic [1:0] on_smp, off_smp, hold, on_ofs, off_ofs;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit mon_en = 1'b0;

  always #4 clk = ~clk;

  rect_phase_ctrl #(.SYNC_STAGES(2), .HOLD_DLY(DLY)) u_rect_phase_ctrl (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .gate_a_i (ga),
    .gate_b_i (gb),
    .on_smp_o (on_smp),
    .off_smp_o(off_smp),
    .hold_o   (hold),
    .on_ofs_o (on_ofs),
    .off_ofs_o(off_ofs)
  );

  // reference model built from the requirements
  logic [1:0] m_s1, m_s2, m_s3;
  logic [1:0] m_on, m_off, m_ono, m_offo;
  int         m_cnt [2];

  always @(posedge clk or negedge rst_n) begin
    logic [1:0] r, f, n_on, n_off, n_ono, n_offo;
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_s3 = '0;
      m_on = '0; m_off = '0; m_ono = '0; m_offo = '0;
      m_cnt[0] = 0; m_cnt[1] = 0;
    end else begin
      r = m_s2 & ~m_s3;
      f = ~m_s2 & m_s3;
      for (int h = 0; h < 2; h++) begin
        if (!m_on[1-h] || m_off[h]) m_cnt[h] = 0;
        else if (m_cnt[h] < DLY)    m_cnt[h] = m_cnt[h] + 1;
        n_on[h]   = r[h]   ? 1'b0 : (f[1-h] ? 1'b1 : m_on[h]);
        n_off[h]  = f[h]   ? 1'b0 : (f[1-h] ? 1'b1 : m_off[h]);
        n_ono[h]  = r[h]   ? 1'b0 : (f[1-h] ? 1'b1 : m_ono[h]);
        n_offo[h] = f[1-h] ? 1'b0 : (r[h]   ? 1'b1 : m_offo[h]);
      end
      m_on = n_on; m_off = n_off; m_ono = n_ono; m_offo = n_offo;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = {gb, ga};
    end
  end

  function automatic logic exp_hold(int h);
    return m_on[1-h] && !m_off[h] && (m_cnt[h] == DLY);
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en && rst_n) begin
      for (int h = 0; h < 2; h++) begin
        chk("R2 on_smp", on_smp[h], m_on[h]);
        chk("R3 off_smp", off_smp[h], m_off[h]);
        chk("R4 on_ofs", on_ofs[h], m_ono[h]);
        chk("R5 off_ofs", off_ofs[h], m_offo[h]);
        chk("R7 hold", hold[h], exp_hold(h));
        if (off_smp[h]) chk("R8 hold blocked", hold[h], 1'b0);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    step(3);
    chk("R1 reset on_smp", |on_smp, 1'b0);
    chk("R1 reset off_smp", |off_smp, 1'b0);
    chk("R1 reset hold/ofs", |{hold, on_ofs, off_ofs}, 1'b0);
    rst_n = 1'b1;
    step(4);
    chk("R1 idle after reset", |{on_smp, off_smp, hold, on_ofs, off_ofs}, 1'b0);
    mon_en = 1'b1;

    gb = 1'b1; step(6);
    gb = 1'b0; step(2);
    chk("R10 not yet visible", on_smp[0], 1'b0);
    step(1);
    chk("R10 visible after edge k+2", on_smp[0], 1'b1);
    chk("R9 bit mapping", on_smp == 2'b01, 1'b1);
    chk("R3 off window open", off_smp[0], 1'b1);
    step(DLY - 1);
    chk("R7 hold still low", hold[1], 1'b0);
    step(1);
    chk("R7 hold rises after DLY", hold[1], 1'b1);
    step(2);
    ga = 1'b1; step(3);
    chk("R7 hold drops with window", hold[1], 1'b0);
    chk("R5 off_ofs set by own rise", off_ofs[0], 1'b1);
    ga = 1'b0; step(3);
    chk("R3 off window closed", off_smp[0], 1'b0);

    ga = 1'b0; gb = 1'b1; step(6);
    ga = 1'b1; gb = 1'b0; step(3);
    chk("R6 clear wins on_smp", on_smp[0], 1'b0);
    chk("R6 clear wins on_ofs", on_ofs[0], 1'b0);
    chk("R6 clear wins off_ofs", off_ofs[0], 1'b0);
    chk("R6 set alone off_smp", off_smp[0], 1'b1);

    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (($urandom % 6) == 0) ga = ~ga;
      if (($urandom % 6) == 0) gb = ~gb;
      if (($urandom % 40) == 0) begin ga = ~ga; gb = ~gb; end
    end
    step(8);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule